// File: doc/BRIEF.md
# Packed Unsigned Halving Add/Subtract Unit

This execution block performs unsigned halving arithmetic on packed data. Two 32-bit source values are split into lanes: either two 16-bit halves or four 8-bit bytes. Each lane forms a sum or a difference with one extra bit of precision and then halves it, so no lane can overflow. Two crossed halfword modes pair each half of the first source with the opposite half of the second source. In these modes one lane adds and the other subtracts.

The unit decodes a 32-bit instruction word itself. That word supplies the condition code, the destination index and the lane operation. The unit tests the condition against the current N, Z, C and V flags. One clock after an input is accepted, it presents the destination index, a write enable and the packed result, with a valid strobe. The register file that supplies the sources and consumes the result is outside the block.

Top module: `phalve_unit`

## Requirements
- R1: One clock after a cycle with `in_valid` high, `out_valid` is high and `out_dest` equals instruction bits 15:12. In every other cycle after reset, `out_valid` is low.
- R2: Operation field bits 7:5 = 0 gives two 16-bit lanes. Each lane is (a lane + b lane) >> 1, and the carry becomes the lane's top bit.
- R3: Operation field = 3 gives two 16-bit lanes. Each lane is (a lane − b lane) >> 1 computed on 17 bits, so a borrow sets the lane's top bit.
- R4: Operation field = 1 gives result[15:0] = (a[15:0] − b[31:16]) >> 1 and result[31:16] = (a[31:16] + b[15:0]) >> 1.
- R5: Operation field = 2 gives result[15:0] = (a[15:0] + b[31:16]) >> 1 and result[31:16] = (a[31:16] − b[15:0]) >> 1.
- R6: Operation field = 4 gives four byte lanes, each (a byte + b byte) >> 1 with the carry as the top bit.
- R7: Operation field = 7 gives four byte lanes, each (a byte − b byte) >> 1 with the borrow as the top bit.
- R8: No carry or borrow passes from one lane into another.
- R9: Operation fields 5 and 6 produce `out_wen` = 0 and `out_result` = 0.
- R10: Condition bits 31:28 = 0xE always write. Condition 0xF never writes.
- R11: Condition codes 0x0 to 0xD are tested against `flags` = {N,Z,C,V} (bit 3 = N, bit 0 = V). The codes in order are EQ, NE, CS, CC, MI, PL, VS, VC, HI, LS, GE, LT, GT, LE. When the test fails, `out_wen` is 0 and the result is still produced.
- R12: A synchronous active-low reset clears `out_valid`, `out_wen`, `out_dest` and `out_result`. While `in_valid` is low, `out_result`, `out_dest` and `out_wen` keep their values.
- R13: Instruction bits 27:20, 11:8 and 4 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction and operands present this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | First source value (a) |
| src_b | input | 32 | Second source value (b) |
| flags | input | 4 | Condition flags {N,Z,C,V} |
| out_valid | output | 1 | Registered result strobe |
| out_dest | output | 4 | Destination register index |
| out_wen | output | 1 | Destination write enable |
| out_result | output | 32 | Packed halved result |

## Verification
Halfword lanes are driven with all-ones plus one and with small-minus-larger operands. These values show whether the carry or the borrow reaches each lane's top bit. Byte patterns alternate 0xFF and 0x80 across neighbouring lanes, which exposes any carry that leaks between lanes. Asymmetric halves in the crossed modes show whether the halves are swapped and whether add and subtract land in the right lane. A sweep over every condition code under several flag settings, a batch of random mixed operations and repeats with junk filler bits set separate condition decoding, the handling of unsupported operations and field isolation.

// File: rtl/phalve_pkg.sv
// Shared constants and types for the packed halving unit.
// Assumes a 32-bit instruction word with fixed field positions.
package phalve_pkg;
    localparam int INSTR_W  = 32;
    localparam int COND_HI  = 31;
    localparam int COND_LO  = 28;
    localparam int DEST_HI  = 15;
    localparam int DEST_LO  = 12;
    localparam int OP_HI    = 7;
    localparam int OP_LO    = 5;
    localparam int COND_W   = COND_HI - COND_LO + 1;
    localparam int DEST_W   = DEST_HI - DEST_LO + 1;
    localparam int OP_W     = OP_HI - OP_LO + 1;

    // Lane operation encodings carried in the operation field.
    typedef enum logic [OP_W-1:0] {
        OP_HALF_ADD = 3'd0,
        OP_HALF_ASX = 3'd1,
        OP_HALF_SAX = 3'd2,
        OP_HALF_SUB = 3'd3,
        OP_BYTE_ADD = 3'd4,
        OP_RSVD5    = 3'd5,
        OP_RSVD6    = 3'd6,
        OP_BYTE_SUB = 3'd7
    } lane_op_e;

    // Lane control derived from the operation field.
    typedef struct packed {
        logic       supported;
        logic       use_bytes;
        logic       swap_b;
        logic [1:0] half_sub;
        logic       byte_sub;
    } lane_ctrl_t;

    localparam logic [COND_W-1:0] COND_ALWAYS = 4'hE;
    localparam logic [COND_W-1:0] COND_NEVER  = 4'hF;
endpackage

// File: rtl/phalve_cond.sv
// Condition evaluator: decides whether an instruction may write.
// Assumes flags are packed {N,Z,C,V}; code 0xE always passes, 0xF never.
module phalve_cond
    import phalve_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  logic [3:0]        flags,
    output logic              pass
);
    logic n_f, z_f, c_f, v_f;
    assign {n_f, z_f, c_f, v_f} = flags;

    // Map each condition code onto its flag test.
    always_comb begin
        unique case (cond)
            4'h0: pass = z_f;
            4'h1: pass = !z_f;
            4'h2: pass = c_f;
            4'h3: pass = !c_f;
            4'h4: pass = n_f;
            4'h5: pass = !n_f;
            4'h6: pass = v_f;
            4'h7: pass = !v_f;
            4'h8: pass = c_f && !z_f;
            4'h9: pass = !c_f || z_f;
            4'hA: pass = (n_f == v_f);
            4'hB: pass = (n_f != v_f);
            4'hC: pass = !z_f && (n_f == v_f);
            4'hD: pass = z_f || (n_f != v_f);
            4'hE: pass = 1'b1;
            default: pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/phalve_decode.sv
// Operation decoder: turns the operation field into lane controls.
// Assumes values 5 and 6 are reserved and must not write.
module phalve_decode
    import phalve_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output lane_ctrl_t      ctrl
);
    // Select lane width, operand swap and per-lane add or subtract.
    always_comb begin
        ctrl = '0;
        unique case (lane_op_e'(op))
            OP_HALF_ADD: begin ctrl.supported = 1'b1; end
            OP_HALF_ASX: begin ctrl.supported = 1'b1; ctrl.swap_b = 1'b1; ctrl.half_sub = 2'b01; end
            OP_HALF_SAX: begin ctrl.supported = 1'b1; ctrl.swap_b = 1'b1; ctrl.half_sub = 2'b10; end
            OP_HALF_SUB: begin ctrl.supported = 1'b1; ctrl.half_sub = 2'b11; end
            OP_BYTE_ADD: begin ctrl.supported = 1'b1; ctrl.use_bytes = 1'b1; end
            OP_BYTE_SUB: begin ctrl.supported = 1'b1; ctrl.use_bytes = 1'b1; ctrl.byte_sub = 1'b1; end
            default:     begin ctrl = '0; end
        endcase
    end
endmodule

// File: rtl/phalve_lanes.sv
// Lane array: LANES independent lanes of LANE_W bits. Each lane adds or
// subtracts at LANE_W+1 bits and keeps the upper LANE_W bits (a halving).
// Assumes no interaction between lanes.
module phalve_lanes #(
    parameter int LANE_W = 16,
    parameter int LANES  = 2,
    localparam int VEC_W = LANE_W * LANES
) (
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    input  logic [LANES-1:0] sub_mask,
    output logic [VEC_W-1:0] res
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] a_l, b_l;
        logic [LANE_W:0]   wide;
        assign a_l = a[g*LANE_W +: LANE_W];
        assign b_l = b[g*LANE_W +: LANE_W];
        // Extended add or subtract, carry/borrow lands in the top bit.
        always_comb begin
            if (sub_mask[g]) wide = {1'b0, a_l} - {1'b0, b_l};
            else             wide = {1'b0, a_l} + {1'b0, b_l};
        end
        assign res[g*LANE_W +: LANE_W] = wide[LANE_W:1];
    end
endmodule

// File: rtl/phalve_unit.sv
// Packed unsigned halving add/subtract unit (top).
// Decodes the instruction, evaluates the condition, computes halfword or byte
// lane results and registers them one clock after in_valid.
// Assumes DATA_W is divisible by 4; synchronous active-low reset.
module phalve_unit
    import phalve_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [INSTR_W-1:0]   instr,
    input  logic [DATA_W-1:0]    src_a,
    input  logic [DATA_W-1:0]    src_b,
    input  logic [3:0]           flags,
    output logic                 out_valid,
    output logic [DEST_W-1:0]    out_dest,
    output logic                 out_wen,
    output logic [DATA_W-1:0]    out_result
);
    localparam int HALF_W = DATA_W / 2;
    localparam int BYTE_W = DATA_W / 4;

    lane_ctrl_t        ctrl;
    logic              cond_ok;
    logic [DATA_W-1:0] b_half;
    logic [DATA_W-1:0] half_res;
    logic [DATA_W-1:0] byte_res;
    logic [DATA_W-1:0] result_d;

    phalve_decode u_dec (
        .op   (instr[OP_HI:OP_LO]),
        .ctrl (ctrl)
    );

    phalve_cond u_cond (
        .cond  (instr[COND_HI:COND_LO]),
        .flags (flags),
        .pass  (cond_ok)
    );

    // Crossed modes exchange the halves of the second operand.
    assign b_half = ctrl.swap_b ? {src_b[HALF_W-1:0], src_b[DATA_W-1:HALF_W]} : src_b;

    phalve_lanes #(.LANE_W(HALF_W), .LANES(2)) u_half (
        .a        (src_a),
        .b        (b_half),
        .sub_mask (ctrl.half_sub),
        .res      (half_res)
    );

    phalve_lanes #(.LANE_W(BYTE_W), .LANES(4)) u_byte (
        .a        (src_a),
        .b        (src_b),
        .sub_mask ({4{ctrl.byte_sub}}),
        .res      (byte_res)
    );

    // Choose the lane array output; reserved operations yield zero.
    always_comb begin
        if (!ctrl.supported)    result_d = '0;
        else if (ctrl.use_bytes) result_d = byte_res;
        else                     result_d = half_res;
    end

    // Output register: strobe every cycle, payload only on accepted input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_dest   <= '0;
            out_wen    <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_dest   <= instr[DEST_HI:DEST_LO];
                out_wen    <= cond_ok && ctrl.supported;
                out_result <= result_d;
            end
        end
    end
endmodule

// File: rtl/phalve_chk.sv
// Property checker for phalve_unit, attached by bind.
// Assumes the default 32-bit layout for the lane-level properties.
module phalve_chk
    import phalve_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [INSTR_W-1:0]   instr,
    input logic [DATA_W-1:0]    src_a,
    input logic [DATA_W-1:0]    src_b,
    input logic [3:0]           flags,
    input logic                 out_valid,
    input logic [DEST_W-1:0]    out_dest,
    input logic                 out_wen,
    input logic [DATA_W-1:0]    out_result
);
    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_dest_field_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_dest == $past(instr[DEST_HI:DEST_LO]));
    assert_byte_add_lane0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[OP_HI:OP_LO] == 3'd4) |=>
        ({1'b0, out_result[7:0]} == (({1'b0, $past(src_a[7:0])} + {1'b0, $past(src_b[7:0])}) >> 1)));
    assert_cross_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[OP_HI:OP_LO] == 3'd1) |=>
        ({1'b0, out_result[31:16]} == (({1'b0, $past(src_a[31:16])} + {1'b0, $past(src_b[15:0])}) >> 1)));
    assert_reserved_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (instr[OP_HI:OP_LO] == 3'd5 || instr[OP_HI:OP_LO] == 3'd6)) |=> !out_wen);
    assert_never_cond_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[COND_HI:COND_LO] == COND_NEVER) |=> !out_wen);
    assert_always_cond_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[COND_HI:COND_LO] == COND_ALWAYS && instr[OP_HI:OP_LO] == 3'd0) |=> out_wen);
    assert_eq_fail_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[COND_HI:COND_LO] == 4'h0 && !flags[2]) |=> !out_wen);
    assert_hold_result_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result) && $stable(out_dest) && $stable(out_wen));
endmodule

bind phalve_unit phalve_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/phalve_unit_tb.sv
// Scoreboard bench for phalve_unit: the driver queues expected results from
// an independent model; a monitor pops and compares each registered output.
module phalve_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] instr, src_a, src_b;
    logic [3:0]  flags;
    logic        out_valid;
    logic [3:0]  out_dest;
    logic        out_wen;
    logic [31:0] out_result;

    int checks = 0;
    int failures = 0;
    logic [36:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] last_res;

    always #2 clk = ~clk;

    phalve_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .src_a(src_a), .src_b(src_b), .flags(flags), .out_valid(out_valid),
        .out_dest(out_dest), .out_wen(out_wen), .out_result(out_result)
    );

    function automatic logic [15:0] hl(input int x, input int y, input bit sub);
        int s;
        s = sub ? (x - y) : (x + y);
        s = s >>> 1;
        return s[15:0];
    endfunction

    function automatic logic [7:0] bl(input int x, input int y, input bit sub);
        int s;
        s = sub ? (x - y) : (x + y);
        s = s >>> 1;
        return s[7:0];
    endfunction

    // Reference model: returns {wen, result}.
    function automatic logic [32:0] model(input logic [31:0] ins, input logic [31:0] a,
                                          input logic [31:0] b, input logic [3:0] f);
        bit n, z, c, v, go, ok;
        logic [31:0] r;
        {n, z, c, v} = f;
        case (ins[31:28])
            4'h0: go = z;          4'h1: go = !z;
            4'h2: go = c;          4'h3: go = !c;
            4'h4: go = n;          4'h5: go = !n;
            4'h6: go = v;          4'h7: go = !v;
            4'h8: go = c && !z;    4'h9: go = !c || z;
            4'hA: go = n == v;     4'hB: go = n != v;
            4'hC: go = !z && n == v;
            4'hD: go = z || n != v;
            4'hE: go = 1;
            default: go = 0;
        endcase
        ok = 1;
        case (ins[7:5])
            3'd0: r = {hl(a[31:16], b[31:16], 0), hl(a[15:0], b[15:0], 0)};
            3'd1: r = {hl(a[31:16], b[15:0], 0), hl(a[15:0], b[31:16], 1)};
            3'd2: r = {hl(a[31:16], b[15:0], 1), hl(a[15:0], b[31:16], 0)};
            3'd3: r = {hl(a[31:16], b[31:16], 1), hl(a[15:0], b[15:0], 1)};
            3'd4: r = {bl(a[31:24], b[31:24], 0), bl(a[23:16], b[23:16], 0),
                       bl(a[15:8], b[15:8], 0), bl(a[7:0], b[7:0], 0)};
            3'd7: r = {bl(a[31:24], b[31:24], 1), bl(a[23:16], b[23:16], 1),
                       bl(a[15:8], b[15:8], 1), bl(a[7:0], b[7:0], 1)};
            default: begin r = 0; ok = 0; end
        endcase
        return {go && ok, r};
    endfunction

    function automatic logic [31:0] mk(input logic [3:0] cnd, input logic [3:0] rd,
                                       input logic [2:0] op);
        return {cnd, 8'h00, 4'h0, rd, 4'h0, op, 5'h0};
    endfunction

    task automatic check(input bit good, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!good) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: present one instruction and queue its expected outcome.
    task automatic issue(input string tag, input logic [31:0] ins, input logic [31:0] a,
                         input logic [31:0] b, input logic [3:0] f);
        logic [32:0] m;
        @(negedge clk);
        instr = ins; src_a = a; src_b = b; flags = f; in_valid = 1'b1;
        m = model(ins, a, b, f);
        exp_q.push_back({ins[15:12], m});
        tag_q.push_back(tag);
        last_res = m[31:0];
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: compare each produced result against the queue head.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R1 unexpected out_valid", 64'(out_result), 64'h0);
            end else begin
                logic [36:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({out_dest, out_wen, out_result} == e, t,
                      64'({out_dest, out_wen, out_result}), 64'(e));
            end
        end
    end

    initial begin : watchdog
        #400000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0; in_valid = 1'b1; instr = '1; src_a = '1; src_b = '1; flags = '0;
        repeat (3) @(negedge clk);
        // R12: reset clears outputs even with in_valid high
        check(out_valid == 0 && out_wen == 0 && out_result == 0 && out_dest == 0, "R12 reset",
              64'({out_valid, out_wen, out_dest, out_result}), 64'h0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 0, "R1 idle after reset", 64'(out_valid), 64'h0);

        // R2 halfword add, carry into top bit
        issue("R2", mk(4'hE, 4'd3, 3'd0), 32'h0003_FFFF, 32'h0001_0001, 4'h0);
        issue("R2", mk(4'hE, 4'd9, 3'd0), 32'hFFFF_1234, 32'hFFFF_4321, 4'h0);
        // R3 halfword subtract, borrow into top bit
        issue("R3", mk(4'hE, 4'd1, 3'd3), 32'h0001_0000, 32'h0002_0001, 4'h0);
        issue("R3", mk(4'hE, 4'd2, 3'd3), 32'h8000_0010, 32'h0001_0004, 4'h0);
        // R4 / R5 crossed modes with asymmetric halves
        issue("R4", mk(4'hE, 4'd4, 3'd1), 32'h1000_0002, 32'h0005_F000, 4'h0);
        issue("R4", mk(4'hE, 4'd5, 3'd1), 32'hFFFF_FFFF, 32'h0001_0003, 4'h0);
        issue("R5", mk(4'hE, 4'd6, 3'd2), 32'h1000_0002, 32'h0005_F000, 4'h0);
        issue("R5", mk(4'hE, 4'd7, 3'd2), 32'h0000_FFFF, 32'h0002_0007, 4'h0);
        // R6 / R7 byte lanes; R8 alternating patterns expose inter-lane carry
        issue("R6", mk(4'hE, 4'd8, 3'd4), 32'h10FF_7F01, 32'h2001_0103, 4'h0);
        issue("R7", mk(4'hE, 4'd10, 3'd7), 32'h0510_0080, 32'h0708_0101, 4'h0);
        issue("R8", mk(4'hE, 4'd11, 3'd4), 32'h80FF_80FF, 32'h8001_8001, 4'h0);
        issue("R8", mk(4'hE, 4'd12, 3'd7), 32'h0001_0001, 32'h0100_0100, 4'h0);
        issue("R8", mk(4'hE, 4'd13, 3'd0), 32'h0000_FFFF, 32'h0000_0003, 4'h0);
        // R9 reserved operations
        issue("R9", mk(4'hE, 4'd14, 3'd5), 32'h1234_5678, 32'h1111_1111, 4'h0);
        issue("R9", mk(4'hE, 4'd15, 3'd6), 32'h1234_5678, 32'h1111_1111, 4'h0);
        // R10 always and never
        issue("R10", mk(4'hE, 4'd1, 3'd4), 32'h0202_0202, 32'h0202_0202, 4'hF);
        issue("R10", mk(4'hF, 4'd2, 3'd4), 32'h0202_0202, 32'h0202_0202, 4'hF);
        issue("R10", mk(4'hF, 4'd2, 3'd0), 32'h0202_0202, 32'h0202_0202, 4'h0);
        // R11 every condition code under several flag sets
        for (int cc = 0; cc < 14; cc++) begin
            for (int fv = 0; fv < 16; fv += 3) begin
                issue("R11", mk(4'(cc), 4'(cc), 3'd0), 32'h0004_0006, 32'h0002_0002, 4'(fv));
            end
        end
        // R13 filler bits set must not change the outcome
        issue("R13", mk(4'hE, 4'd5, 3'd1) | 32'h0FF0_0F10, 32'hABCD_1234, 32'h5678_9ABC, 4'h0);
        issue("R13", mk(4'h0, 4'd6, 3'd7) | 32'h0FF0_0F10, 32'hABCD_1234, 32'h5678_9ABC, 4'h4);
        idle(3);
        // R12 hold while idle
        check(out_valid == 0 && out_result == last_res, "R12 hold",
              64'({out_valid, out_result}), 64'({1'b0, last_res}));

        // Mixed random traffic, tagged R8 for lane independence
        for (int i = 0; i < 400; i++) begin
            issue("R8", $urandom(), $urandom(), $urandom(), 4'($urandom()));
        end
        idle(3);
        check(exp_q.size() == 0, "R1 drained", 64'(exp_q.size()), 64'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule